// File: doc/BRIEF.md
# DMA Channel Register Access Decoder

This block holds the per-channel transfer registers of a four-channel DMA controller and gives a host processor byte-wide access to them. Each channel owns a 16-bit starting address and a 16-bit transfer length. Each of the two is kept twice: a base copy that keeps the programmed value and a current copy that the transfer engine works on. The host reaches them over an 8-bit bus using an active-low chip select, active-low read and write strobes, and a 4-bit register address.

Every 16-bit value needs two byte accesses, low byte first. A single byte-order flag, shared by all channels and all registers, chooses which half an access reaches. The flag flips once when each qualifying access finishes. The host can force it back to the low half with a clear input.

A host write puts its byte into the base and the current copy together. A host read always returns the current copy. A load port lets the transfer engine replace a channel's current address and current length without touching the base copies. An engine-side view port shows all four registers of one selected channel.

Top module: `dma_chan_regfile`

## Requirements
- R1: An access qualifies only when `cs_n` is 0, exactly one of `rd_n`/`wr_n` is 0, and `addr[3]` is 0. Any other combination changes no register and leaves the byte-order flag as it is.
- R2: `addr[2:1]` selects the channel (0 to 3). `addr[0]` = 0 selects the address pair and `addr[0]` = 1 selects the length pair.
- R3: While the byte-order flag is 0, an access reaches bits 7:0 of the register. While it is 1, the access reaches bits 15:8.
- R4: The flag flips exactly once per qualifying access, on the clock after the strobe stops qualifying, however long the strobe was held.
- R5: Reset clears the flag and all registers to 0. `ptr_clr` forces the flag to 0 on the next clock and takes priority over a flip.
- R6: A qualifying write stores `wdata` into the selected byte of both the base and the current register, on the first clock edge of the access.
- R7: A read returns the selected byte of the current register, never the base register.
- R8: `rdata_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. `rdata` carries the register byte only during a qualifying read and is 0 at all other times.
- R9: A pulse on `ld_en` replaces the current address and current length of `ld_chan` on the next clock and leaves every base register unchanged.
- R10: When a load and a host write reach the same current register on the same clock, the written byte lands on top of the loaded value and the other byte comes from the load.
- R11: The `eng_*` outputs show, without delay, the four registers of the channel chosen by `eng_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address: bit 3 block select, bits 2:1 channel, bit 0 pair |
| wdata | input | 8 | Write byte from host |
| rdata | output | 8 | Read byte to host |
| rdata_oe | output | 1 | Read bus drive enable |
| ptr_clr | input | 1 | Force byte-order flag to low half |
| ld_en | input | 1 | Engine load strobe |
| ld_chan | input | 2 | Engine load channel |
| ld_addr | input | 16 | New current address |
| ld_count | input | 16 | New current length |
| eng_sel | input | 2 | Engine view channel |
| eng_base_addr | output | 16 | Base address of viewed channel |
| eng_base_count | output | 16 | Base length of viewed channel |
| eng_cur_addr | output | 16 | Current address of viewed channel |
| eng_cur_count | output | 16 | Current length of viewed channel |

## Verification
The properties assume that the host strobes are synchronous to `clk` and stay stable around each edge. They also assume that the end of an access is seen on a clock edge, so the flip happens one cycle after the release. The stimulus changes every input 2 ns after a rising edge and holds each strobe for at least one full cycle. The mirroring property assumes no engine load lands on the same clock as a host write. The bench breaks that assumption only once, on purpose, to exercise R10, and checks the result at the ports.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic {SEL_ADDR = 1'b0, SEL_CNT = 1'b1} pair_e;

  // Replace one half of a register with a bus byte.
  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
    logic [REG_W-1:0] r;
    r = old;
    if (hi) r[REG_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  // Extract one half of a register for the bus.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                  input logic hi);
    return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode import dma_rf_pkg::*; #(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [CHW+1:0] addr,
  output logic           wr_fire,
  output logic           acc_end,
  output logic           rd_sel,
  output logic [CHW-1:0] chan,
  output pair_e          pair
);
  logic acc_rd, acc_wr, rd_q, wr_q;

  assign acc_rd = !cs_n && !rd_n &&  wr_n && !addr[CHW+1];
  assign acc_wr = !cs_n &&  rd_n && !wr_n && !addr[CHW+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= acc_rd;
      wr_q <= acc_wr;
    end
  end

  assign wr_fire = acc_wr && !wr_q;
  assign acc_end = (rd_q && !acc_rd) || (wr_q && !acc_wr);
  assign rd_sel  = acc_rd;
  assign chan    = addr[CHW:1];
  assign pair    = pair_e'(addr[0]);
endmodule

// File: rtl/dma_rf_ptr.sv
module dma_rf_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_q <= 1'b0;
    else if (clr)  hi_q <= 1'b0;
    else if (flip) hi_q <= ~hi_q;
  end
endmodule

// File: rtl/dma_rf_bank.sv
module dma_rf_bank import dma_rf_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_fire,
  input  logic [CHW-1:0]               chan,
  input  pair_e                        pair,
  input  logic                         hi,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic                         ld_en,
  input  logic [CHW-1:0]               ld_chan,
  input  logic [REG_W-1:0]             ld_addr,
  input  logic [REG_W-1:0]             ld_count,
  output logic [NUM_CH-1:0][REG_W-1:0] base_addr,
  output logic [NUM_CH-1:0][REG_W-1:0] base_cnt,
  output logic [NUM_CH-1:0][REG_W-1:0] cur_addr,
  output logic [NUM_CH-1:0][REG_W-1:0] cur_cnt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit_a, hit_c, ld;
    logic [REG_W-1:0] ba_q, bc_q, ca_q, cc_q, ca_nx, cc_nx;

    assign hit_a = wr_fire && (chan == CHW'(c)) && (pair == SEL_ADDR);
    assign hit_c = wr_fire && (chan == CHW'(c)) && (pair == SEL_CNT);
    assign ld    = ld_en && (ld_chan == CHW'(c));

    always_comb begin
      ca_nx = ld ? ld_addr  : ca_q;
      cc_nx = ld ? ld_count : cc_q;
      if (hit_a) ca_nx = merge_byte(ca_nx, wdata, hi);
      if (hit_c) cc_nx = merge_byte(cc_nx, wdata, hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ba_q <= '0;
        bc_q <= '0;
        ca_q <= '0;
        cc_q <= '0;
      end else begin
        if (hit_a) ba_q <= merge_byte(ba_q, wdata, hi);
        if (hit_c) bc_q <= merge_byte(bc_q, wdata, hi);
        ca_q <= ca_nx;
        cc_q <= cc_nx;
      end
    end

    assign base_addr[c] = ba_q;
    assign base_cnt[c]  = bc_q;
    assign cur_addr[c]  = ca_q;
    assign cur_cnt[c]   = cc_q;
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile import dma_rf_pkg::*; #(
  parameter  int NUM_CH = 4,
  localparam int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [CHW+1:0]    addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic              ptr_clr,
  input  logic              ld_en,
  input  logic [CHW-1:0]    ld_chan,
  input  logic [REG_W-1:0]  ld_addr,
  input  logic [REG_W-1:0]  ld_count,
  input  logic [CHW-1:0]    eng_sel,
  output logic [REG_W-1:0]  eng_base_addr,
  output logic [REG_W-1:0]  eng_base_count,
  output logic [REG_W-1:0]  eng_cur_addr,
  output logic [REG_W-1:0]  eng_cur_count
);
  // Named internal events, observed by the bound checker.
  logic                         wr_fire, acc_end, rd_sel, hi_q;
  logic [CHW-1:0]               chan;
  pair_e                        pair;
  logic [NUM_CH-1:0][REG_W-1:0] base_addr, base_cnt, cur_addr, cur_cnt;
  logic [REG_W-1:0]             sel_val;

  dma_rf_decode #(.CHW(CHW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wr_fire(wr_fire), .acc_end(acc_end), .rd_sel(rd_sel),
    .chan(chan), .pair(pair)
  );

  dma_rf_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .flip(acc_end), .hi_q(hi_q)
  );

  dma_rf_bank #(.NUM_CH(NUM_CH), .CHW(CHW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .chan(chan), .pair(pair),
    .hi(hi_q), .wdata(wdata), .ld_en(ld_en), .ld_chan(ld_chan),
    .ld_addr(ld_addr), .ld_count(ld_count), .base_addr(base_addr),
    .base_cnt(base_cnt), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  assign sel_val  = (pair == SEL_CNT) ? cur_cnt[chan] : cur_addr[chan];
  assign rdata    = rd_sel ? pick_byte(sel_val, hi_q) : '0;
  assign rdata_oe = !cs_n && !rd_n;

  assign eng_base_addr  = base_addr[eng_sel];
  assign eng_base_count = base_cnt[eng_sel];
  assign eng_cur_addr   = cur_addr[eng_sel];
  assign eng_cur_count  = cur_cnt[eng_sel];
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk import dma_rf_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cs_n,
  input logic                         rdata_oe,
  input logic                         ptr_clr,
  input logic                         ld_en,
  input logic                         wr_fire,
  input logic                         acc_end,
  input logic                         rd_sel,
  input logic                         hi_q,
  input logic [CHW-1:0]               chan,
  input pair_e                        pair,
  input logic [NUM_CH-1:0][REG_W-1:0] base_addr,
  input logic [NUM_CH-1:0][REG_W-1:0] base_cnt,
  input logic [NUM_CH-1:0][REG_W-1:0] cur_addr,
  input logic [NUM_CH-1:0][REG_W-1:0] cur_cnt
);
  // R4
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end && !ptr_clr |=> hi_q != $past(hi_q));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_end && !ptr_clr |=> $stable(hi_q));

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !hi_q);

  // R9
  base_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(base_addr) && $stable(base_cnt));

  // R6
  wr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !ld_en |=>
      (($past(pair) == SEL_ADDR) ?
        (pick_byte(cur_addr[$past(chan)], $past(hi_q)) ==
         pick_byte(base_addr[$past(chan)], $past(hi_q))) :
        (pick_byte(cur_cnt[$past(chan)], $past(hi_q)) ==
         pick_byte(base_cnt[$past(chan)], $past(hi_q)))));

  // R7
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel && !ld_en |=> $stable(cur_addr) && $stable(cur_cnt));

  // R8
  oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !cs_n);
endmodule

bind dma_chan_regfile dma_rf_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdata_oe(rdata_oe),
  .ptr_clr(ptr_clr), .ld_en(ld_en), .wr_fire(wr_fire), .acc_end(acc_end),
  .rd_sel(rd_sel), .hi_q(hi_q), .chan(chan), .pair(pair),
  .base_addr(base_addr), .base_cnt(base_cnt), .cur_addr(cur_addr),
  .cur_cnt(cur_cnt)
);

// File: tb/sim_dma_chan_regfile.sv
module sim_dma_chan_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic        ptr_clr = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_chan = '0;
  logic [15:0] ld_addr = '0, ld_count = '0;
  logic [1:0]  eng_sel = '0;
  logic [15:0] eng_base_addr, eng_base_count, eng_cur_addr, eng_cur_count;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_chan_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .ptr_clr(ptr_clr), .ld_en(ld_en), .ld_chan(ld_chan), .ld_addr(ld_addr),
    .ld_count(ld_count), .eng_sel(eng_sel), .eng_base_addr(eng_base_addr),
    .eng_base_count(eng_base_count), .eng_cur_addr(eng_cur_addr),
    .eng_cur_count(eng_cur_count)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_ba[4], m_bc[4], m_ca[4], m_cc[4];
  int m_ptr = 0;
  bit m_pr = 0, m_pw = 0;

  function automatic int put(int v, int b, int p);
    if (p == 0) return (v & 'hFF00) | b;
    return (v & 'h00FF) | (b * 256);
  endfunction

  function automatic bit q_rd();
    return !cs_n && !rd_n && wr_n && !addr[3];
  endfunction

  always @(posedge clk) begin : model
    bit qr, qw, fin;
    int ch;
    if (!rst_n) begin
      foreach (m_ba[i]) begin m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; end
      m_ptr = 0; m_pr = 0; m_pw = 0;
    end else begin
      qr = q_rd();
      qw = !cs_n && rd_n && !wr_n && !addr[3];
      ch = int'(addr[2:1]);
      if (ld_en) begin
        m_ca[ld_chan] = int'(ld_addr);
        m_cc[ld_chan] = int'(ld_count);
      end
      if (qw && !m_pw) begin
        if (addr[0] == 1'b0) begin
          m_ba[ch] = put(m_ba[ch], int'(wdata), m_ptr);
          m_ca[ch] = put(m_ca[ch], int'(wdata), m_ptr);
        end else begin
          m_bc[ch] = put(m_bc[ch], int'(wdata), m_ptr);
          m_cc[ch] = put(m_cc[ch], int'(wdata), m_ptr);
        end
      end
      fin = (m_pr && !qr) || (m_pw && !qw);
      if (ptr_clr)  m_ptr = 0;
      else if (fin) m_ptr = 1 - m_ptr;
      m_pr = qr;
      m_pw = qw;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin : compare
    int v, exp_rd;
    if (rst_n && !done) begin
      chk("R11 base addr", int'(eng_base_addr), m_ba[eng_sel]);
      chk("R11 base count", int'(eng_base_count), m_bc[eng_sel]);
      chk("R11 cur addr", int'(eng_cur_addr), m_ca[eng_sel]);
      chk("R11 cur count", int'(eng_cur_count), m_cc[eng_sel]);
      chk("R8 oe", int'(rdata_oe), int'(!cs_n && !rd_n));
      v = addr[0] ? m_cc[addr[2:1]] : m_ca[addr[2:1]];
      exp_rd = q_rd() ? (m_ptr ? (v / 256) % 256 : v % 256) : 0;
      chk("R8 rdata", int'(rdata), exp_rd);
    end
  end

  task automatic wr_byte(logic [3:0] a, logic [7:0] d, int hold = 2);
    @(posedge clk); #2; cs_n = 0; wr_n = 0; addr = a; wdata = d;
    repeat (hold) @(posedge clk);
    #2; cs_n = 1; wr_n = 1;
    @(posedge clk);
  endtask

  task automatic wr_word(logic [3:0] a, logic [15:0] v);
    wr_byte(a, v[7:0]);
    wr_byte(a, v[15:8]);
  endtask

  task automatic rd_byte(logic [3:0] a, int exp, string tag);
    @(posedge clk); #2; cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk);
    chk(tag, int'(rdata), exp);
    @(posedge clk); #2; cs_n = 1; rd_n = 1;
    @(posedge clk);
  endtask

  task automatic rd_word(logic [3:0] a, int exp, string tag);
    rd_byte(a, exp % 256, tag);
    rd_byte(a, exp / 256, tag);
  endtask

  task automatic raw(logic c, logic r, logic w, logic [3:0] a, logic [7:0] d, int n);
    @(posedge clk); #2; cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d;
    repeat (n) @(posedge clk);
    #2; cs_n = 1; rd_n = 1; wr_n = 1;
    @(posedge clk);
  endtask

  task automatic pulse_clr();
    @(posedge clk); #2; ptr_clr = 1;
    @(posedge clk); #2; ptr_clr = 0;
  endtask

  task automatic eng_chk(logic [1:0] ch, int ba, int bc, int ca, int cc, string tag);
    eng_sel = ch; #1;
    chk({tag, " base addr"}, int'(eng_base_addr), ba);
    chk({tag, " base count"}, int'(eng_base_count), bc);
    chk({tag, " cur addr"}, int'(eng_cur_addr), ca);
    chk({tag, " cur count"}, int'(eng_cur_count), cc);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    eng_chk(2'd0, 0, 0, 0, 0, "R5 reset");
    chk("R8 oe idle", int'(rdata_oe), 0);

    // R6 R3: channel 0 address, low then high byte
    wr_word(4'b0000, 16'h1234);
    eng_chk(2'd0, 'h1234, 0, 'h1234, 0, "R6");
    rd_word(4'b0000, 'h1234, "R3");

    // R2: channel 2 length pair
    wr_word(4'b0101, 16'hBEEF);
    rd_word(4'b0101, 'hBEEF, "R2 ch2 count");
    rd_word(4'b0100, 0, "R2 ch2 addr");
    eng_chk(2'd2, 0, 'hBEEF, 0, 'hBEEF, "R2");

    // R4: long-held strobe flips the flag once
    wr_byte(4'b0110, 8'h5A, 6);
    wr_byte(4'b0110, 8'hA5, 2);
    eng_chk(2'd3, 'hA55A, 0, 'hA55A, 0, "R4");

    // R5: clear returns to the low byte
    wr_byte(4'b0110, 8'h11);
    pulse_clr();
    wr_byte(4'b0110, 8'h22);
    pulse_clr();
    eng_chk(2'd3, 'hA522, 0, 'hA522, 0, "R5");

    // R1: non-qualifying accesses are ignored
    raw(1'b0, 1'b1, 1'b0, 4'b1000, 8'hFF, 2);
    raw(1'b0, 1'b0, 1'b0, 4'b0000, 8'hEE, 2);
    raw(1'b1, 1'b1, 1'b0, 4'b0000, 8'hDD, 2);
    eng_chk(2'd0, 'h1234, 0, 'h1234, 0, "R1");
    rd_word(4'b0000, 'h1234, "R1 flag unchanged");

    // R9 R7: engine load touches current only; reads return current
    @(posedge clk); #2; ld_en = 1; ld_chan = 2'd0; ld_addr = 16'h0F0F; ld_count = 16'h7777;
    @(posedge clk); #2; ld_en = 0;
    eng_chk(2'd0, 'h1234, 0, 'h0F0F, 'h7777, "R9");
    rd_word(4'b0000, 'h0F0F, "R7 addr");
    rd_word(4'b0001, 'h7777, "R7 count");

    // R10: load and host write on the same clock
    @(posedge clk); #2; cs_n = 0; wr_n = 0; addr = 4'b0010; wdata = 8'h11;
    ld_en = 1; ld_chan = 2'd1; ld_addr = 16'hAB00; ld_count = 16'h0303;
    @(posedge clk); #2; ld_en = 0;
    @(posedge clk); #2; cs_n = 1; wr_n = 1;
    @(posedge clk);
    eng_chk(2'd1, 'h0011, 0, 'hAB11, 'h0303, "R10");
    pulse_clr();

    // R8: drive enable outside the register window
    @(posedge clk); #2; cs_n = 0; rd_n = 0; addr = 4'b1010;
    @(negedge clk);
    chk("R8 oe high", int'(rdata_oe), 1);
    chk("R8 rdata zero", int'(rdata), 0);
    @(posedge clk); #2; cs_n = 1;
    @(negedge clk);
    chk("R8 oe low", int'(rdata_oe), 0);
    @(posedge clk); #2; rd_n = 1;
    rd_word(4'b0010, 'hAB11, "R8 R1 flag after window");

    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule